// File: doc/BRIEF.md
# Halfword Load/Store Address Unit

This unit carries out one halfword or signed-byte single data transfer for a 32-bit load/store processor. It takes a decoded instruction word and reads three registers through combinational register-file read ports: the base, the register offset and the store source. It then works out the effective address and places one read or write request on a memory port that uses a valid/ready handshake. When the transfer completes, it returns the register writebacks and a cycle count in a single strobe.

Four operations are supported: unsigned halfword load, halfword store, signed halfword load and signed byte load. Each can use pre- or post-indexing, an offset that is added or subtracted, and an offset that comes from an immediate or from a register. The base register is always written back. The one exception is a load whose destination is also its base: there the loaded value wins and the base writeback is dropped. The reported cycle count is the base cost of the operation plus the number of cycles the memory held off the request.

Top module: `hls_xfer_unit`

## Requirements
- R1: After reset the unit is idle: `ins_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: With instruction bit 24 set (pre-index), the access address is the base plus or minus the offset, and the base writeback value is that same address.
- R3: With bit 24 clear (post-index), the access address is the unmodified base value, and the base writeback value is the base plus or minus the offset.
- R4: The base register is selected by bits 19:16, the data register by bits 15:12 and the offset register by bits 3:0. Bit 23 set adds the offset and bit 23 clear subtracts it. Bit 22 set selects the immediate {bits 11:8, bits 3:0}, zero-extended; bit 22 clear selects the value of the offset register.
- R5: Bit 20 set means a load. For loads, bits 6:5 = 11 sign-extends `mem_rsp_data[15:0]` from bit 15, bits 6:5 = 10 sign-extends `mem_rsp_data[7:0]` from bit 7, and any other value zero-extends `mem_rsp_data[15:0]`. The result is written to the data register.
- R6: Bit 20 clear means a halfword store. `mem_req_write` is 1, `mem_req_wdata` carries the low 16 bits of the source register, and no data-register writeback occurs.
- R7: `mem_req_size` is 00 (byte) for a signed byte load and 01 (halfword) for every other operation.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction, size and write data stay unchanged into the next cycle.
- R9: An instruction is accepted only while `ins_ready` is high. A valid instruction presented while the unit is busy is ignored and starts no further request.
- R10: A load whose base and data registers are the same register writes only the loaded value: `wb_base_en` stays 0.
- R11: `done` is a one-cycle pulse in the cycle after the request handshake. The writeback enables are high only together with `done`.
- R12: `cycles` equals 3 plus the number of wait cycles for a load, and 2 plus the number of wait cycles for a store. A wait cycle is a cycle with the request valid and ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word is presented |
| ins_word | input | 32 | Instruction word |
| ins_ready | output | 1 | Unit is idle and accepts an instruction |
| rf_base_idx | output | 4 | Base register read index |
| rf_base_val | input | 32 | Base register value |
| rf_off_idx | output | 4 | Offset register read index |
| rf_off_val | input | 32 | Offset register value |
| rf_src_idx | output | 4 | Data/source register read index |
| rf_src_val | input | 32 | Source register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request (read data valid this cycle) |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_size | output | 2 | 00 byte, 01 halfword |
| mem_req_addr | output | 32 | Access address |
| mem_req_wdata | output | 16 | Store data |
| mem_rsp_data | input | 16 | Read data, sampled at the handshake |
| done | output | 1 | Transfer complete strobe |
| wb_base_en | output | 1 | Base writeback enable |
| wb_base_idx | output | 4 | Base writeback register |
| wb_base_val | output | 32 | Base writeback value |
| wb_data_en | output | 1 | Loaded-data writeback enable |
| wb_data_idx | output | 4 | Data writeback register |
| wb_data_val | output | 32 | Extended loaded value |
| cycles | output | 8 | Total cycle count for the transfer |

## Verification
Several properties are checked on every clock: the request holding steady under backpressure, `done` falling one cycle after the handshake, the writeback enables appearing only with `done`, the absence of two writebacks to one register, the size encoding a store may use, and the lower bound on `cycles`. Only the bench scenarios, checked against bench-computed values, can show that the address arithmetic, the indexing modes, the immediate assembly, each extension rule and the exact wait-cycle accounting give correct numbers. The same holds for a busy-time instruction leaving no trace.

// File: rtl/hls_pkg.sv
package hls_pkg;

    parameter int XLEN       = 32;
    parameter int RIDX_W     = 4;
    parameter int HALF_W     = 16;
    parameter int CYC_W      = 8;
    parameter int LOAD_COST  = 3;
    parameter int STORE_COST = 2;

    localparam int IMM_W = 8;

    typedef enum logic [1:0] {
        XOP_LDUH = 2'd0,
        XOP_STH  = 2'd1,
        XOP_LDSH = 2'd2,
        XOP_LDSB = 2'd3
    } xop_e;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01
    } acc_size_e;

    typedef struct packed {
        xop_e              op;
        logic              pre;
        logic              up;
        logic              imm_sel;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rm;
        logic [IMM_W-1:0]  imm8;
    } xfer_dec_t;

    function automatic xfer_dec_t xfer_decode(input logic [XLEN-1:0] w);
        xfer_dec_t d;
        if (!w[20])
            d.op = XOP_STH;
        else if (w[6:5] == 2'b11)
            d.op = XOP_LDSH;
        else if (w[6:5] == 2'b10)
            d.op = XOP_LDSB;
        else
            d.op = XOP_LDUH;
        d.pre     = w[24];
        d.up      = w[23];
        d.imm_sel = w[22];
        d.rb      = w[19:16];
        d.rd      = w[15:12];
        d.rm      = w[3:0];
        d.imm8    = {w[11:8], w[3:0]};
        return d;
    endfunction

    function automatic logic is_load(input xop_e op);
        return op != XOP_STH;
    endfunction

    function automatic acc_size_e access_size(input xop_e op);
        return (op == XOP_LDSB) ? ACC_BYTE : ACC_HALF;
    endfunction

    function automatic logic [CYC_W-1:0] base_cost(input xop_e op);
        return is_load(op) ? CYC_W'(LOAD_COST) : CYC_W'(STORE_COST);
    endfunction

endpackage

// File: rtl/hls_addr_gen.sv
module hls_addr_gen
    import hls_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic             pre,
    input  logic             up,
    input  logic             imm_sel,
    input  logic [IMM_W-1:0] imm8,
    input  logic [W-1:0]     base_val,
    input  logic [W-1:0]     reg_off,
    output logic [W-1:0]     acc_addr,
    output logic [W-1:0]     new_base
);
    logic [W-1:0] offset;
    logic [W-1:0] moved;

    always_comb begin
        offset   = imm_sel ? {{(W-IMM_W){1'b0}}, imm8} : reg_off;
        moved    = up ? (base_val + offset) : (base_val - offset);
        acc_addr = pre ? moved : base_val;
        new_base = moved;
    end
endmodule

// File: rtl/hls_load_ext.sv
module hls_load_ext
    import hls_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int HW = HALF_W
) (
    input  xop_e          op,
    input  logic [HW-1:0] raw,
    output logic [W-1:0]  value
);
    localparam int BW = HW / 2;

    always_comb begin
        unique case (op)
            XOP_LDSH: value = {{(W-HW){raw[HW-1]}}, raw};
            XOP_LDSB: value = {{(W-BW){raw[BW-1]}}, raw[BW-1:0]};
            default:  value = {{(W-HW){1'b0}}, raw};
        endcase
    end
endmodule

// File: rtl/hls_seq_ctrl.sv
module hls_seq_ctrl #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mem_ready,
    output logic          idle,
    output logic          req_valid,
    output logic          handshake,
    output logic          done_pulse,
    output logic [CW-1:0] wait_cnt
);
    typedef enum logic {S_IDLE, S_REQ} seq_state_e;

    localparam logic [CW-1:0] WAIT_MAX = {CW{1'b1}};

    seq_state_e state;

    assign idle      = (state == S_IDLE);
    assign req_valid = (state == S_REQ);
    assign handshake = req_valid && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            wait_cnt   <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state    <= S_REQ;
                        wait_cnt <= '0;
                    end
                end
                S_REQ: begin
                    if (mem_ready) begin
                        state      <= S_IDLE;
                        done_pulse <= 1'b1;
                    end else if (wait_cnt != WAIT_MAX) begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hls_xfer_unit.sv
module hls_xfer_unit
    import hls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [XLEN-1:0]   ins_word,
    output logic              ins_ready,
    output logic [RIDX_W-1:0] rf_base_idx,
    input  logic [XLEN-1:0]   rf_base_val,
    output logic [RIDX_W-1:0] rf_off_idx,
    input  logic [XLEN-1:0]   rf_off_val,
    output logic [RIDX_W-1:0] rf_src_idx,
    input  logic [XLEN-1:0]   rf_src_val,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [1:0]        mem_req_size,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [HALF_W-1:0] mem_req_wdata,
    input  logic [HALF_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              wb_base_en,
    output logic [RIDX_W-1:0] wb_base_idx,
    output logic [XLEN-1:0]   wb_base_val,
    output logic              wb_data_en,
    output logic [RIDX_W-1:0] wb_data_idx,
    output logic [XLEN-1:0]   wb_data_val,
    output logic [CYC_W-1:0]  cycles
);
    localparam int SUM_W = CYC_W + 1;
    localparam logic [SUM_W-1:0] CYC_MAX = SUM_W'({CYC_W{1'b1}});

    xfer_dec_t dec_in;
    xfer_dec_t dec_q;
    logic [XLEN-1:0] addr_in, base_in;
    logic [XLEN-1:0] addr_q, base_q;
    logic [HALF_W-1:0] wdata_q;
    logic [XLEN-1:0] ext_val;
    logic idle, start, hs;
    logic [CYC_W-1:0] wait_cnt;
    logic [SUM_W-1:0] cyc_sum;
    wire unused_src_hi = ^rf_src_val[XLEN-1:HALF_W];

    assign dec_in      = xfer_decode(ins_word);
    assign rf_base_idx = dec_in.rb;
    assign rf_off_idx  = dec_in.rm;
    assign rf_src_idx  = dec_in.rd;
    assign start       = ins_valid && idle;
    assign ins_ready   = idle;

    hls_addr_gen #(.W(XLEN)) u_addr (
        .pre      (dec_in.pre),
        .up       (dec_in.up),
        .imm_sel  (dec_in.imm_sel),
        .imm8     (dec_in.imm8),
        .base_val (rf_base_val),
        .reg_off  (rf_off_val),
        .acc_addr (addr_in),
        .new_base (base_in)
    );

    hls_seq_ctrl #(.CW(CYC_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mem_ready  (mem_req_ready),
        .idle       (idle),
        .req_valid  (mem_req_valid),
        .handshake  (hs),
        .done_pulse (done),
        .wait_cnt   (wait_cnt)
    );

    hls_load_ext #(.W(XLEN), .HW(HALF_W)) u_ext (
        .op    (dec_q.op),
        .raw   (mem_rsp_data),
        .value (ext_val)
    );

    // capture of the transfer at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q   <= '0;
            addr_q  <= '0;
            base_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            dec_q   <= dec_in;
            addr_q  <= addr_in;
            base_q  <= base_in;
            wdata_q <= rf_src_val[HALF_W-1:0];
        end
    end

    assign mem_req_addr  = addr_q;
    assign mem_req_write = !is_load(dec_q.op);
    assign mem_req_size  = access_size(dec_q.op);
    assign mem_req_wdata = wdata_q;

    assign cyc_sum = SUM_W'(base_cost(dec_q.op)) + SUM_W'(wait_cnt);

    // writeback formation at the handshake; loaded data outranks the base
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_base_en  <= 1'b0;
            wb_data_en  <= 1'b0;
            wb_base_idx <= '0;
            wb_data_idx <= '0;
            wb_base_val <= '0;
            wb_data_val <= '0;
            cycles      <= '0;
        end else begin
            wb_base_en <= 1'b0;
            wb_data_en <= 1'b0;
            if (hs) begin
                wb_base_en  <= !(is_load(dec_q.op) && (dec_q.rb == dec_q.rd));
                wb_data_en  <= is_load(dec_q.op);
                wb_base_idx <= dec_q.rb;
                wb_data_idx <= dec_q.rd;
                wb_base_val <= base_q;
                wb_data_val <= ext_val;
                cycles      <= (cyc_sum > CYC_MAX) ? {CYC_W{1'b1}} : cyc_sum[CYC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/hls_xfer_unit_chk.sv
module hls_xfer_unit_chk
    import hls_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ins_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [1:0]        mem_req_size,
    input logic [XLEN-1:0]   mem_req_addr,
    input logic [HALF_W-1:0] mem_req_wdata,
    input logic              done,
    input logic              wb_base_en,
    input logic [RIDX_W-1:0] wb_base_idx,
    input logic              wb_data_en,
    input logic [RIDX_W-1:0] wb_data_idx,
    input logic [CYC_W-1:0]  cycles
);
    a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ins_ready && !mem_req_valid && !done));

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_size) && $stable(mem_req_wdata)));

    a_r9_busy_blocks_accept: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !ins_ready);

    a_r11_done_after_hs: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> done);

    a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        (wb_base_en || wb_data_en) |-> done);

    a_r10_single_writer: assert property (@(posedge clk) disable iff (rst)
        (wb_base_en && wb_data_en) |-> (wb_base_idx != wb_data_idx));

    a_r6_store_no_data_wb: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && mem_req_write) |=> (done && !wb_data_en));

    a_r7_store_is_half: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_size == 2'b01));

    a_r12_cycles_floor: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles >= CYC_W'(STORE_COST)));
endmodule

bind hls_xfer_unit hls_xfer_unit_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ins_ready     (ins_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_size  (mem_req_size),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done          (done),
    .wb_base_en    (wb_base_en),
    .wb_base_idx   (wb_base_idx),
    .wb_data_en    (wb_data_en),
    .wb_data_idx   (wb_data_idx),
    .cycles        (cycles)
);

// File: tb/hls_xfer_unit_tb.sv
module hls_xfer_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid;
    logic [31:0] ins_word;
    logic        ins_ready;
    logic [3:0]  rf_base_idx, rf_off_idx, rf_src_idx;
    logic [31:0] rf_base_val, rf_off_val, rf_src_val;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [1:0]  mem_req_size;
    logic [31:0] mem_req_addr;
    logic [15:0] mem_req_wdata, mem_rsp_data;
    logic        done, wb_base_en, wb_data_en;
    logic [3:0]  wb_base_idx, wb_data_idx;
    logic [31:0] wb_base_val, wb_data_val;
    logic [7:0]  cycles;

    logic [31:0] rf [16];
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign rf_base_val = rf[rf_base_idx];
    assign rf_off_val  = rf[rf_off_idx];
    assign rf_src_val  = rf[rf_src_idx];

    hls_xfer_unit u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ext_model(input logic [31:0] w, input logic [15:0] d);
        if (w[6:5] == 2'b11) return {{16{d[15]}}, d};
        if (w[6:5] == 2'b10) return {{24{d[7]}}, d[7:0]};
        return {16'h0, d};
    endfunction

    // one transfer: waits = stall cycles, poke = present a second word while busy
    task automatic run_op(input logic [31:0] w, input int waits, input logic [15:0] rdata,
                          input bit poke);
        logic [31:0] bv, off, moved, e_addr;
        logic        ld, e_base_en;
        logic [1:0]  e_size;
        bv    = rf[w[19:16]];
        off   = w[22] ? {24'h0, w[11:8], w[3:0]} : rf[w[3:0]];
        moved = w[23] ? bv + off : bv - off;
        e_addr = w[24] ? moved : bv;
        ld    = w[20];
        e_size = (ld && w[6:5] == 2'b10) ? 2'b00 : 2'b01;
        e_base_en = !(ld && w[19:16] == w[15:12]);

        chk("R9 ready when idle", ins_ready, 1);
        ins_valid = 1'b1;
        ins_word  = w;
        @(posedge clk);
        @(negedge clk);
        ins_valid = poke;
        ins_word  = ~w;
        for (int k = 0; k < waits; k++) begin
            chk("R8 valid while stalled", mem_req_valid, 1);
            chk("R9 busy not ready", ins_ready, 0);
            chk("R2 R3 address", mem_req_addr, e_addr);
            @(negedge clk);
        end
        ins_valid = 1'b0;
        chk("R8 valid at handshake", mem_req_valid, 1);
        chk("R2 R3 R4 address", mem_req_addr, e_addr);
        chk("R5 R6 direction", mem_req_write, !ld);
        chk("R7 size", mem_req_size, e_size);
        if (!ld) chk("R6 store data", mem_req_wdata, rf[w[15:12]][15:0]);
        mem_req_ready = 1'b1;
        mem_rsp_data  = rdata;
        @(posedge clk);
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R11 done pulse", done, 1);
        chk("R10 base enable", wb_base_en, e_base_en);
        if (e_base_en) begin
            chk("R4 base index", wb_base_idx, w[19:16]);
            chk("R2 R3 base value", wb_base_val, moved);
        end
        chk("R6 data enable", wb_data_en, ld);
        if (ld) begin
            chk("R4 data index", wb_data_idx, w[15:12]);
            chk("R5 extension", wb_data_val, ext_model(w, rdata));
        end
        chk("R12 cycles", cycles, (ld ? 3 : 2) + waits);
        chk("R9 busy word ignored", mem_req_valid, 0);
        @(negedge clk);
        chk("R11 done falls", done, 0);
        chk("R9 no second request", mem_req_valid, 0);
    endtask

    function automatic logic [31:0] mk(input bit pre, input bit up, input bit imm,
                                       input bit ld, input logic [1:0] sh,
                                       input logic [3:0] rb, input logic [3:0] rd,
                                       input logic [3:0] hi, input logic [3:0] lo);
        return {7'h0, pre, up, imm, 1'b0, ld, rb, rd, hi, 1'b1, sh, 1'b1, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed1234);
        for (int i = 0; i < 16; i++) rf[i] = $urandom;
        rst = 1'b1; ins_valid = 1'b0; ins_word = '0;
        mem_req_ready = 1'b0; mem_rsp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", ins_ready, 1);
        chk("R1 no request", mem_req_valid, 0);
        chk("R1 no done", done, 0);

        rf[2] = 32'h0000_1000; rf[5] = 32'h0000_0030; rf[7] = 32'hCAFE_8001;
        // R2 pre-index, add immediate 0x3C, unsigned half with bit15 set
        run_op(mk(1, 1, 1, 1, 2'b01, 4'd2, 4'd7, 4'h3, 4'hC), 0, 16'h8001, 0);
        // R3 post-index, subtract register offset, signed half negative
        run_op(mk(0, 0, 0, 1, 2'b11, 4'd2, 4'd7, 4'h0, 4'd5), 2, 16'hFF80, 0);
        // R5 signed byte negative, byte access, high byte ignored
        run_op(mk(1, 0, 1, 1, 2'b10, 4'd2, 4'd7, 4'h0, 4'h4), 1, 16'h12F0, 0);
        // R5 signed byte positive
        run_op(mk(0, 1, 1, 1, 2'b10, 4'd2, 4'd7, 4'h0, 4'h2), 0, 16'hAB7F, 0);
        // R10 load with base == dest
        run_op(mk(1, 1, 1, 1, 2'b11, 4'd7, 4'd7, 4'h1, 4'h0), 3, 16'h1234, 0);
        // R6 store, pre-index subtract, stalled, busy-time word presented
        run_op(mk(1, 0, 0, 0, 2'b01, 4'd2, 4'd7, 4'h0, 4'd5), 4, 16'h0, 1);
        // R6 store with base == source keeps base writeback
        run_op(mk(0, 1, 1, 0, 2'b01, 4'd7, 4'd7, 4'hF, 4'hF), 0, 16'h0, 0);
        // R12 long stall on a load
        run_op(mk(0, 1, 0, 1, 2'b00, 4'd5, 4'd2, 4'h0, 4'd2), 9, 16'h00FF, 0);

        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < 16; i++) rf[i] = $urandom;
            run_op($urandom, $urandom_range(0, 5), 16'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule